// File: doc/BRIEF.md
# Short Vector Exception Capture Unit

This unit steps a short vector floating-point operation through its iterations, one per clock. For each iteration it presents that iteration's destination and source register addresses. It also follows each iteration down to the stage where the arithmetic pipeline reports exceptions. When an iteration reports a potential exception, the unit stops issuing. It then freezes a status word with the cause flags and the number of iterations still to run. It also keeps a copy of the vector instruction whose register fields now name the exceptional iteration, so a handler can finish the work and resume the rest.

The instruction that follows the vector operation is held in decode through a stall output for as long as the operation runs. After an exception that instruction stays stalled, and it is retried once the handler leaves the exceptional state by pulsing the clear input. A second instruction already in flight behind the vector operation can be saved into a second slot along with a valid flag. When no such instruction is pending, the flag is cleared.

Top module: `vec_exc_capture`

## Requirements
- R1: After reset, `status_o` is zero, and `stall_o`, `iter_valid_o` and `sec_valid_o` are low.
- R2: An accepted issue with length field L (`len_i`) produces L+1 consecutive cycles of `iter_valid_o`, starting the cycle after the issue. `iter_idx_o` counts 0 to L. For example, 3'b011 gives four iterations.
- R3: Iteration 0 uses the addresses taken from the instruction word. The 5-bit address is {extension bit, 4-bit field}: destination is {bit 22, bits 15:12}, first source is {bit 7, bits 19:16} and second source is {bit 5, bits 3:0}. Each later iteration adds the step to address bits 2:0 modulo 8 and keeps bits 4:3. The step is 1 for stride field 2'b00 and 2 for any other stride value.
- R4: A nonzero `cause_i` in the third cycle after an iteration is presented (the cycle whose number is that iteration's cycle plus 3) is an exception for that iteration. From the next cycle, status bit 9 (exceptional state) and bit 8 (enable) are 1, and `iter_valid_o` is low.
- R5: On an exception, status bits 3:0 take `cause_i`: bit 0 invalid operation, bit 1 overflow, bit 2 underflow, bit 3 input exception. Flags whose cause bit is clear stay 0.
- R6: On an exception in iteration i of an operation with length field L, status bits 6:4 hold (L - i - 1) modulo 8. This is the number of iterations left after i, minus one. So with L=3 and i=0, the field is 3'b010.
- R7: On an exception, `cap_word_o` equals the issued word with its three register fields (same positions as R3) replaced by iteration i's addresses. All other bits are unchanged.
- R8: On an exception, status bit 7 and `sec_valid_o` take `pend2_valid_i`. When `pend2_valid_i` is high, `sec_word_o` takes `pend2_word_i`.
- R9: `stall_o` is high from the cycle after an accepted issue through the cycle in which the last iteration's exception window ends (L+4 cycles in all). It is low afterwards. An issue while `stall_o` is high is ignored.
- R10: While status bit 9 is set, issues are ignored, `iter_valid_o` stays low, `stall_o` stays high, and the status word and captured word hold. A pulse on `clear_i` zeroes the status word, and `stall_o` falls in the next cycle.
- R11: A nonzero `cause_i` when no iteration is in its exception window leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe for a vector instruction |
| instr_i | input | 32 | Vector instruction word holding the register fields |
| len_i | input | 3 | Length field: iteration count minus one |
| stride_i | input | 2 | Stride field: 2'b00 step 1, otherwise step 2 |
| cause_i | input | 4 | Exception cause flags from the arithmetic pipeline |
| pend2_valid_i | input | 1 | A second instruction is in flight behind the vector operation |
| pend2_word_i | input | 32 | That second instruction |
| clear_i | input | 1 | Handler done: leave the exceptional state |
| iter_valid_o | output | 1 | An iteration is presented this cycle |
| iter_idx_o | output | 3 | Index of the presented iteration |
| iter_dst_o | output | 5 | Destination address of the iteration |
| iter_srcn_o | output | 5 | First source address of the iteration |
| iter_srcm_o | output | 5 | Second source address of the iteration |
| status_o | output | 10 | Exceptional-state status word |
| cap_word_o | output | 32 | Captured instruction with rewritten register fields |
| sec_valid_o | output | 1 | Second slot holds a valid instruction |
| sec_word_o | output | 32 | Second-instruction slot |
| stall_o | output | 1 | Hold the following instruction in decode |

## Verification
The assertions assume that reset is held for several cycles, so every `$past` sees a reset value. They also assume that `clear_i` is a single-cycle pulse, and that the pipeline reports a cause only for an iteration that is in its exception window. The one exception to that last point is the case that R11 declares to be ignored. The stimulus drives every input on the falling clock edge. It raises `cause_i` only in the single cycle three after the chosen iteration, except in a deliberate stray-cause scenario. It issues new operations only after `stall_o` has fallen, apart from the scenarios that test that an issue is ignored.

// File: rtl/vec_exc_pkg.sv
package vec_exc_pkg;
  localparam int REG_W    = 4;
  localparam int ADDR_W   = REG_W + 1;
  localparam int BANK_W   = 3;
  localparam int LEN_W    = 3;
  localparam int STRIDE_W = 2;
  localparam int WORD_W   = 32;
  localparam int CAUSE_W  = 4;

  // register field positions inside the instruction word
  localparam int FD_LO = 12;
  localparam int FN_LO = 16;
  localparam int FM_LO = 0;
  localparam int D_BIT = 22;
  localparam int N_BIT = 7;
  localparam int M_BIT = 5;

  // status word layout
  localparam int ST_EX     = 9;
  localparam int ST_EN     = 8;
  localparam int ST_SECV   = 7;
  localparam int ST_REM_LO = 4;
  localparam int STATUS_W  = 10;

  typedef logic [ADDR_W-1:0] vaddr_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [LEN_W-1:0] idx;
    vaddr_t           d;
    vaddr_t           n;
    vaddr_t           m;
  } iter_t;

  function automatic vaddr_t get_d(input word_t w);
    return {w[D_BIT], w[FD_LO +: REG_W]};
  endfunction

  function automatic vaddr_t get_n(input word_t w);
    return {w[N_BIT], w[FN_LO +: REG_W]};
  endfunction

  function automatic vaddr_t get_m(input word_t w);
    return {w[M_BIT], w[FM_LO +: REG_W]};
  endfunction

  function automatic word_t put_regs(input word_t w, input vaddr_t d,
                                     input vaddr_t n, input vaddr_t m);
    word_t r;
    r = w;
    r[FD_LO +: REG_W] = d[REG_W-1:0];
    r[D_BIT]          = d[REG_W];
    r[FN_LO +: REG_W] = n[REG_W-1:0];
    r[N_BIT]          = n[REG_W];
    r[FM_LO +: REG_W] = m[REG_W-1:0];
    r[M_BIT]          = m[REG_W];
    return r;
  endfunction

  // advance inside a bank: low bits wrap, bank bits kept
  function automatic vaddr_t step_addr(input vaddr_t a, input logic [BANK_W-1:0] s);
    return {a[ADDR_W-1:BANK_W], a[BANK_W-1:0] + s};
  endfunction
endpackage

// File: rtl/vec_iter_seq.sv
module vec_iter_seq
  import vec_exc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [LEN_W-1:0]    len,
  input  logic [STRIDE_W-1:0] stride,
  input  word_t               word,
  input  logic                flush,
  output logic                cur_valid,
  output iter_t               cur
);
  logic              valid_q;
  iter_t             cur_q;
  logic [LEN_W-1:0]  left_q;
  logic [BANK_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cur_q   <= '0;
      left_q  <= '0;
      step_q  <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
      left_q  <= '0;
    end else if (start) begin
      valid_q   <= 1'b1;
      cur_q.idx <= '0;
      cur_q.d   <= get_d(word);
      cur_q.n   <= get_n(word);
      cur_q.m   <= get_m(word);
      left_q    <= len;
      step_q    <= (stride == '0) ? BANK_W'(1) : BANK_W'(2);
    end else if (valid_q && left_q != '0) begin
      cur_q.idx <= cur_q.idx + 1'b1;
      cur_q.d   <= step_addr(cur_q.d, step_q);
      cur_q.n   <= step_addr(cur_q.n, step_q);
      cur_q.m   <= step_addr(cur_q.m, step_q);
      left_q    <= left_q - 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign cur_valid = valid_q;
  assign cur       = cur_q;

  // R3: consecutive iterations stay in their bank and count up
  p_bank_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_q && $past(valid_q)) |->
      (cur_q.d[ADDR_W-1:BANK_W] == $past(cur_q.d[ADDR_W-1:BANK_W]) &&
       cur_q.n[ADDR_W-1:BANK_W] == $past(cur_q.n[ADDR_W-1:BANK_W]) &&
       cur_q.m[ADDR_W-1:BANK_W] == $past(cur_q.m[ADDR_W-1:BANK_W]) &&
       cur_q.idx == $past(cur_q.idx) + 1'b1));

  // R2: a started operation begins at iteration zero
  p_start_idx_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !flush) |=> (valid_q && cur_q.idx == '0));
endmodule

// File: rtl/vec_exc_pipe.sv
module vec_exc_pipe
  import vec_exc_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  flush,
  input  logic  in_valid,
  input  iter_t in_iter,
  output logic  any_valid,
  output logic  out_valid,
  output iter_t out_iter
);
  logic  vq [DEPTH];
  iter_t iq [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < DEPTH; s++) begin
        vq[s] <= 1'b0;
        iq[s] <= '0;
      end
    end else begin
      vq[0] <= in_valid;
      iq[0] <= in_iter;
      for (int s = 1; s < DEPTH; s++) begin
        vq[s] <= vq[s-1];
        iq[s] <= iq[s-1];
      end
    end
  end

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < DEPTH; s++) any_valid = any_valid | vq[s];
  end

  assign out_valid = vq[DEPTH-1];
  assign out_iter  = iq[DEPTH-1];

  // R2: iterations in flight sit in adjacent stages in issue order
  for (genvar g = 1; g < DEPTH; g++) begin : g_order
    p_stage_order_r2: assert property (@(posedge clk) disable iff (rst)
      (vq[g] && vq[g-1]) |-> (iq[g-1].idx == iq[g].idx + 1'b1));
  end
endmodule

// File: rtl/vec_exc_record.sv
module vec_exc_record
  import vec_exc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  word_t               word,
  input  logic [LEN_W-1:0]    len,
  input  logic                detect,
  input  logic [CAUSE_W-1:0]  cause,
  input  iter_t               iter,
  input  logic                pend_valid,
  input  word_t               pend_word,
  input  logic                clear,
  output logic [STATUS_W-1:0] status,
  output word_t               cap_word,
  output word_t               sec_word
);
  word_t               op_word_q;
  logic [LEN_W-1:0]    op_len_q;
  logic [STATUS_W-1:0] status_q;
  word_t               cap_q;
  word_t               sec_q;
  logic [STATUS_W-1:0] status_d;
  logic [LEN_W-1:0]    rem;

  assign rem = op_len_q - iter.idx - 1'b1;

  always_comb begin
    status_d                              = '0;
    status_d[ST_EX]                       = 1'b1;
    status_d[ST_EN]                       = 1'b1;
    status_d[ST_SECV]                     = pend_valid;
    status_d[ST_REM_LO +: LEN_W]          = rem;
    status_d[CAUSE_W-1:0]                 = cause;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_word_q <= '0;
      op_len_q  <= '0;
      status_q  <= '0;
      cap_q     <= '0;
      sec_q     <= '0;
    end else begin
      if (start) begin
        op_word_q <= word;
        op_len_q  <= len;
      end
      if (clear) begin
        status_q <= '0;
      end else if (detect) begin
        status_q <= status_d;
        cap_q    <= put_regs(op_word_q, iter.d, iter.n, iter.m);
        if (pend_valid) sec_q <= pend_word;
      end
    end
  end

  assign status   = status_q;
  assign cap_word = cap_q;
  assign sec_word = sec_q;

  // R10: the exceptional state freezes the record until clear
  p_hold_in_exc_r10: assert property (@(posedge clk) disable iff (rst)
    (status_q[ST_EX] && !clear) |=> ($stable(status_q) && $stable(cap_q) && $stable(sec_q)));

  // R5: entering the exceptional state always carries some cause
  p_cause_present_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[ST_EX]) |-> (status_q[CAUSE_W-1:0] != '0));

  // R10: a clear empties the status word
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (rst)
    clear |=> (status_q == '0));
endmodule

// File: rtl/vec_exc_capture.sv
module vec_exc_capture
  import vec_exc_pkg::*;
#(
  parameter int DETECT_LAT = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_i,
  input  logic [WORD_W-1:0]   instr_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic                pend2_valid_i,
  input  logic [WORD_W-1:0]   pend2_word_i,
  input  logic                clear_i,
  output logic                iter_valid_o,
  output logic [LEN_W-1:0]    iter_idx_o,
  output logic [ADDR_W-1:0]   iter_dst_o,
  output logic [ADDR_W-1:0]   iter_srcn_o,
  output logic [ADDR_W-1:0]   iter_srcm_o,
  output logic [STATUS_W-1:0] status_o,
  output logic [WORD_W-1:0]   cap_word_o,
  output logic                sec_valid_o,
  output logic [WORD_W-1:0]   sec_word_o,
  output logic                stall_o
);
  logic  cur_valid, pipe_any, chk_valid, in_exc, accept, detect;
  iter_t cur, chk_iter;
  logic [STATUS_W-1:0] status_w;

  assign in_exc  = status_w[ST_EX];
  assign stall_o = cur_valid | pipe_any | in_exc;
  assign accept  = issue_i && !stall_o;
  assign detect  = chk_valid && (cause_i != '0) && !in_exc;

  vec_iter_seq u_seq (
    .clk(clk), .rst(rst), .start(accept), .len(len_i), .stride(stride_i),
    .word(instr_i), .flush(detect), .cur_valid(cur_valid), .cur(cur)
  );

  vec_exc_pipe #(.DEPTH(DETECT_LAT)) u_pipe (
    .clk(clk), .rst(rst), .flush(detect), .in_valid(cur_valid), .in_iter(cur),
    .any_valid(pipe_any), .out_valid(chk_valid), .out_iter(chk_iter)
  );

  vec_exc_record u_rec (
    .clk(clk), .rst(rst), .start(accept), .word(instr_i), .len(len_i),
    .detect(detect), .cause(cause_i), .iter(chk_iter),
    .pend_valid(pend2_valid_i), .pend_word(pend2_word_i), .clear(clear_i),
    .status(status_w), .cap_word(cap_word_o), .sec_word(sec_word_o)
  );

  assign iter_valid_o = cur_valid;
  assign iter_idx_o   = cur.idx;
  assign iter_dst_o   = cur.d;
  assign iter_srcn_o  = cur.n;
  assign iter_srcm_o  = cur.m;
  assign status_o     = status_w;
  assign sec_valid_o  = status_w[ST_SECV];

  // R10: no iteration is presented while exceptional
  p_no_iter_in_exc_r10: assert property (@(posedge clk) disable iff (rst)
    in_exc |=> !cur_valid);

  // R11: the exceptional state is entered only from the check window
  p_detect_window_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(in_exc) |-> $past(chk_valid));

  // R4: entering the exceptional state keeps the follower stalled
  p_exc_stalls_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(in_exc) |-> (stall_o && !cur_valid && status_w[ST_EN]));
endmodule

// File: tb/vec_exc_capture_bench.sv
module vec_exc_capture_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue_i;
  logic [31:0] instr_i;
  logic [2:0]  len_i;
  logic [1:0]  stride_i;
  logic [3:0]  cause_i;
  logic        pend2_valid_i;
  logic [31:0] pend2_word_i;
  logic        clear_i;
  logic        iter_valid_o;
  logic [2:0]  iter_idx_o;
  logic [4:0]  iter_dst_o, iter_srcn_o, iter_srcm_o;
  logic [9:0]  status_o;
  logic [31:0] cap_word_o;
  logic        sec_valid_o;
  logic [31:0] sec_word_o;
  logic        stall_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_exc_capture u_vec_exc_capture (
    .clk(clk), .rst(rst), .issue_i(issue_i), .instr_i(instr_i), .len_i(len_i),
    .stride_i(stride_i), .cause_i(cause_i), .pend2_valid_i(pend2_valid_i),
    .pend2_word_i(pend2_word_i), .clear_i(clear_i), .iter_valid_o(iter_valid_o),
    .iter_idx_o(iter_idx_o), .iter_dst_o(iter_dst_o), .iter_srcn_o(iter_srcn_o),
    .iter_srcm_o(iter_srcm_o), .status_o(status_o), .cap_word_o(cap_word_o),
    .sec_valid_o(sec_valid_o), .sec_word_o(sec_word_o), .stall_o(stall_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [31:0] fill, input logic [4:0] d,
                                          input logic [4:0] n, input logic [4:0] m);
    logic [31:0] w;
    w = fill;
    w[15:12] = d[3:0]; w[22] = d[4];
    w[19:16] = n[3:0]; w[7]  = n[4];
    w[3:0]   = m[3:0]; w[5]  = m[4];
    return w;
  endfunction

  function automatic logic [4:0] ea(input logic [4:0] base, input int j, input int step);
    int b;
    b = int'(base);
    return 5'((b & 24) | ((b + j * step) & 7));
  endfunction

  task automatic t_reset();
    rst = 1'b1; issue_i = 0; instr_i = 0; len_i = 0; stride_i = 0; cause_i = 0;
    pend2_valid_i = 0; pend2_word_i = 0; clear_i = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 status", 32'(status_o), 0);
    check("R1 stall", 32'(stall_o), 0);
    check("R1 iter_valid", 32'(iter_valid_o), 0);
    check("R1 sec_valid", 32'(sec_valid_o), 0);
  endtask

  // one vector operation; ei < 0 means no exception
  task automatic run_op(input int L, input logic [1:0] st, input logic [4:0] bd,
                        input logic [4:0] bn, input logic [4:0] bm, input logic [31:0] fill,
                        input int ei, input logic [3:0] cs, input logic pv,
                        input logic [31:0] pw);
    int step;
    int last;
    logic [31:0] w;
    step = (st == 2'b00) ? 1 : 2;
    last = (ei < 0) ? L + 4 : ei + 4;
    w = mk_word(fill, bd, bn, bm);
    @(negedge clk);
    instr_i = w; len_i = 3'(L); stride_i = st; pend2_valid_i = pv; pend2_word_i = pw;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    for (int j = 0; j < last; j++) begin
      check("R2 iter_valid", 32'(iter_valid_o), 32'(j <= L));
      if (j <= L) begin
        check("R2 iter_idx", 32'(iter_idx_o), 32'(j));
        check("R3 dst", 32'(iter_dst_o), 32'(ea(bd, j, step)));
        check("R3 srcn", 32'(iter_srcn_o), 32'(ea(bn, j, step)));
        check("R3 srcm", 32'(iter_srcm_o), 32'(ea(bm, j, step)));
      end
      check("R9 stall high", 32'(stall_o), 1);
      check("R4 not yet exceptional", 32'(status_o[9]), 0);
      if (ei >= 0 && j == ei + 3) cause_i = cs;
      @(negedge clk);
      cause_i = 4'b0;
    end
    if (ei < 0) begin
      check("R9 stall released", 32'(stall_o), 0);
      check("R2 iter_valid done", 32'(iter_valid_o), 0);
      check("R4 no exception", 32'(status_o), 0);
    end else begin
      check("R4 exc bit", 32'(status_o[9]), 1);
      check("R4 enable bit", 32'(status_o[8]), 1);
      check("R4 iter stopped", 32'(iter_valid_o), 0);
      check("R5 cause flags", 32'(status_o[3:0]), 32'(cs));
      check("R6 remaining", 32'(status_o[6:4]), 32'((L - ei - 1) & 7));
      check("R7 captured word", cap_word_o,
            mk_word(fill, ea(bd, ei, step), ea(bn, ei, step), ea(bm, ei, step)));
      check("R8 sec status bit", 32'(status_o[7]), 32'(pv));
      check("R8 sec_valid", 32'(sec_valid_o), 32'(pv));
      if (pv) check("R8 sec word", sec_word_o, pw);
      check("R10 stall in exc", 32'(stall_o), 1);
    end
  endtask

  task automatic t_exc_blocks();
    logic [9:0]  s0;
    logic [31:0] c0;
    s0 = status_o; c0 = cap_word_o;
    instr_i = mk_word(32'h0, 5'd1, 5'd2, 5'd3); len_i = 3'd2; issue_i = 1'b1;
    cause_i = 4'b0010;
    @(negedge clk);
    issue_i = 1'b0; cause_i = 4'b0;
    @(negedge clk);
    check("R10 no iteration", 32'(iter_valid_o), 0);
    check("R10 status held", 32'(status_o), 32'(s0));
    check("R10 word held", cap_word_o, c0);
    check("R10 stall held", 32'(stall_o), 1);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    check("R10 status cleared", 32'(status_o), 0);
    check("R10 stall cleared", 32'(stall_o), 0);
    check("R10 sec_valid cleared", 32'(sec_valid_o), 0);
  endtask

  task automatic t_stray();
    @(negedge clk);
    cause_i = 4'b0111;
    @(negedge clk);
    cause_i = 4'b0;
    check("R11 idle cause ignored", 32'(status_o), 0);
    // cause early in an operation, before its window
    instr_i = mk_word(32'h0, 5'd9, 5'd10, 5'd11); len_i = 3'd0; stride_i = 2'b00;
    issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0; cause_i = 4'b0010;
    @(negedge clk);
    cause_i = 4'b0;
    check("R11 early cause ignored", 32'(status_o), 0);
    repeat (3) @(negedge clk);
    check("R11 run completes", 32'(stall_o), 0);
    check("R11 status still zero", 32'(status_o), 0);
  endtask

  task automatic t_busy_issue();
    @(negedge clk);
    instr_i = mk_word(32'h0, 5'd2, 5'd3, 5'd4); len_i = 3'd1; stride_i = 2'b00;
    issue_i = 1'b1;
    @(negedge clk);
    check("R9 first iteration", 32'(iter_dst_o), 32'd2);
    instr_i = mk_word(32'h0, 5'd20, 5'd21, 5'd22); len_i = 3'd5;
    @(negedge clk);
    issue_i = 1'b0;
    check("R9 busy issue ignored", 32'(iter_dst_o), 32'd3);
    @(negedge clk);
    check("R9 busy run ends", 32'(iter_valid_o), 0);
    repeat (3) @(negedge clk);
    check("R9 stall low after window", 32'(stall_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    // four iterations, unit stride, overflow in the first one, no second instruction
    run_op(3, 2'b00, 5'd4, 5'd4, 5'd12, 32'h0E300A00, 0, 4'b0010, 1'b0, 32'h0);
    t_exc_blocks();
    t_clear();
    // eight iterations, stride two, wrapping in the bank
    run_op(7, 2'b11, 5'd6, 5'd23, 5'd13, 32'hF1000900, -1, 4'b0, 1'b0, 32'h0);
    // exception in the last iteration with a pending second instruction
    run_op(2, 2'b01, 5'd15, 5'd7, 5'd24, 32'h0A000C40, 2, 4'b0101, 1'b1, 32'hCAFE1234);
    t_clear();
    // single iteration
    run_op(0, 2'b00, 5'd31, 5'd0, 5'd16, 32'h00000000, -1, 4'b0, 1'b0, 32'h0);
    // exception after all iterations have issued
    run_op(5, 2'b00, 5'd5, 5'd14, 5'd27, 32'h12000300, 3, 4'b1000, 1'b1, 32'h55AA00FF);
    t_clear();
    t_stray();
    t_busy_issue();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule